// File: doc/BRIEF.md
# Tunable Quadrature Oscillator Complex Mixer

This block moves a complex baseband stream (an in-phase and a quadrature sample per beat) up or down in frequency by a tunable offset. Its own phase accumulator drives a quarter-wave sine/cosine table. A full complex multiplier combines the oscillator with each sample. Because both operands are complex, the shifted output carries no mirror image, and the wanted signal can be centred on zero frequency.

A direction bit exchanges the sine and cosine buses on their way into the multiplier. This reverses the sign of the shift, so one tuning word serves both sidebands. Samples arrive with a valid strobe at a low sample rate (nominally 50 kHz) on a fast clock. The oscillator advances only when a sample is accepted, and the tuning word is the offset frequency divided by the sample rate, times 2^32. Each result is rounded and saturated back to the input width and leaves the block after a fixed pipeline delay.

Top module: `nco_cmix`

## Requirements
- R1: After reset, out_valid is 0 and out_i/out_q are 0. Both data outputs are 0 in every cycle where out_valid is 0.
- R2: A sample captured at clock edge k gives exactly one out_valid pulse, visible right after edge k+2 (three-stage latency). No output appears without an accepted sample.
- R3: The 32-bit phase accumulator adds tune_word only at edges where in_valid is 1. Each sample uses the accumulator value from before its own addition, so the first sample after reset uses phase 0.
- R4: The phase index p is the top QB+2 accumulator bits. sin(p) = A·sin(2π(p+0.5)/2^(QB+2)), rounded half away from zero, with A = 2^(DW-1)-1. cos(p) = sin((p + 2^QB) mod 2^(QB+2)).
- R5: With shift_down = 0, the full products are y_i = I·cos − Q·sin and y_q = I·sin + Q·cos.
- R6: With shift_down = 1, sine and cosine are exchanged, giving y_i = I·sin − Q·cos and y_q = I·cos + Q·sin.
- R7: Each output is floor((y + 2^(DW-2)) / 2^(DW-1)), which is round half up at DW-1 fraction bits.
- R8: Outputs saturate to the range [−2^(DW-1), 2^(DW-1)−1] in two's complement.
- R9: tune_word and shift_down are sampled per accepted sample. A direction change applies to the sample taken in the same cycle. A tuning change first moves the phase of the next sample.
- R10: A reset asserted mid-stream clears the accumulator and discards samples in flight: no out_valid follows for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_i | input | DW | In-phase sample, two's complement |
| in_q | input | DW | Quadrature sample, two's complement |
| tune_word | input | PHW | Phase step per accepted sample |
| shift_down | input | 1 | 1 exchanges sine and cosine (reverse shift) |
| out_valid | output | 1 | Result strobe |
| out_i | output | DW | Shifted in-phase result |
| out_q | output | DW | Shifted quadrature result |

## Verification
A single accepted sample does two things in the same cycle. It reads the oscillator phase, and it advances that phase with the tuning word presented alongside it. The bench provokes this collision by changing tune_word and shift_down on every back-to-back sample. It also changes them freely during gaps in the strobe, where they must have no effect. An independent phase model and a trigonometric reference judge each output. The direction must act on its own sample, and the new step only on the following one.

// File: rtl/cmix_pkg.sv
package cmix_pkg;
  localparam real HALF_PI = 1.5707963267948966;

  // Quarter-wave entry k of n, offset by half a step so no entry hits zero.
  function automatic int quarter_wave(input int k, input int n, input int amp);
    real x;
    x = real'(amp) * $sin(HALF_PI * (real'(k) + 0.5) / real'(n));
    return $rtoi(x + 0.5);
  endfunction
endpackage

// File: rtl/cmix_phase_acc.sv
module cmix_phase_acc #(
  parameter int PHW = 32,
  parameter int PB  = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic [PHW-1:0] step,
  output logic [PHW-1:0] phase,
  output logic [PB-1:0]  index
);
  logic [PHW-1:0] acc;

  // R3: advances only on accepted samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (adv) acc <= acc + step;
  end

  assign phase = acc;
  assign index = acc[PHW-1 -: PB];
endmodule

// File: rtl/cmix_sincos.sv
module cmix_sincos #(
  parameter int DW = 12,
  parameter int QB = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [QB+1:0]        idx,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o
);
  localparam int PB  = QB + 2;
  localparam int N   = 1 << QB;
  localparam int AMP = (1 << (DW - 1)) - 1;

  logic [DW-1:0] rom [N];

  for (genvar k = 0; k < N; k++) begin : g_rom
    localparam int V = cmix_pkg::quarter_wave(k, N, AMP);
    assign rom[k] = DW'(V);
  end

  // Quadrant symmetry: bit QB mirrors the address, bit QB+1 negates (R4)
  function automatic logic [QB-1:0] fold(input logic [PB-1:0] p);
    return p[QB] ? ~p[QB-1:0] : p[QB-1:0];
  endfunction

  function automatic logic signed [DW-1:0] apply_sign(input logic neg, input logic [DW-1:0] m);
    return neg ? -$signed(m) : $signed(m);
  endfunction

  logic [PB-1:0]        cidx;
  logic signed [DW-1:0] s_nxt, c_nxt;

  assign cidx = idx + PB'(N);

  always_comb begin
    s_nxt = apply_sign(idx[PB-1],  rom[fold(idx)]);
    c_nxt = apply_sign(cidx[PB-1], rom[fold(cidx)]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_o <= '0;
      cos_o <= '0;
    end else begin
      sin_o <= s_nxt;
      cos_o <= c_nxt;
    end
  end
endmodule

// File: rtl/cmix_cmul.sv
module cmix_cmul #(
  parameter int DW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vin,
  input  logic                 swap,
  input  logic signed [DW-1:0] a_i,
  input  logic signed [DW-1:0] a_q,
  input  logic signed [DW-1:0] osc_s,
  input  logic signed [DW-1:0] osc_c,
  output logic                 vout,
  output logic signed [DW-1:0] y_i,
  output logic signed [DW-1:0] y_q
);
  localparam int PW   = 2 * DW + 1;
  localparam int FRAC = DW - 1;
  localparam logic signed [PW:0] HI   = (PW+1)'((1 << (DW - 1)) - 1);
  localparam logic signed [PW:0] LO   = ~HI;
  localparam logic signed [PW:0] HALF = (PW+1)'(1 << (FRAC - 1));

  // R7 + R8: round half up at FRAC bits, then clamp
  function automatic logic signed [DW-1:0] round_sat(input logic signed [PW-1:0] v);
    logic signed [PW:0] t;
    t = $signed({v[PW-1], v}) + HALF;
    t = t >>> FRAC;
    if (t > HI)      return HI[DW-1:0];
    else if (t < LO) return LO[DW-1:0];
    else             return t[DW-1:0];
  endfunction

  logic signed [DW-1:0] use_s, use_c;
  logic signed [PW-1:0] p_i, p_q;
  logic                 v2;

  // R6: direction exchanges the oscillator buses
  assign use_s = swap ? osc_c : osc_s;
  assign use_c = swap ? osc_s : osc_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_i <= '0;
      p_q <= '0;
      v2  <= 1'b0;
    end else begin
      // R5: full complex product
      p_i <= PW'(a_i) * PW'(use_c) - PW'(a_q) * PW'(use_s);
      p_q <= PW'(a_i) * PW'(use_s) + PW'(a_q) * PW'(use_c);
      v2  <= vin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_i  <= '0;
      y_q  <= '0;
      vout <= 1'b0;
    end else begin
      // R1: data held at zero between results
      y_i  <= v2 ? round_sat(p_i) : '0;
      y_q  <= v2 ? round_sat(p_q) : '0;
      vout <= v2;
    end
  end
endmodule

// File: rtl/nco_cmix.sv
module nco_cmix #(
  parameter int DW  = 12,
  parameter int PHW = 32,
  parameter int QB  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [DW-1:0]  in_i,
  input  logic [DW-1:0]  in_q,
  input  logic [PHW-1:0] tune_word,
  input  logic           shift_down,
  output logic           out_valid,
  output logic [DW-1:0]  out_i,
  output logic [DW-1:0]  out_q
);
  localparam int PB = QB + 2;

  // Named internal events for the checker
  logic [PHW-1:0]       acc_phase;
  logic [PB-1:0]        acc_index;
  logic                 acc_step_en;
  logic signed [DW-1:0] osc_s, osc_c;
  logic signed [DW-1:0] s1_i, s1_q;
  logic                 s1_v, s1_dir;
  logic signed [DW-1:0] r_i, r_q;

  assign acc_step_en = in_valid;

  cmix_phase_acc #(.PHW(PHW), .PB(PB)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (acc_step_en),
    .step  (tune_word),
    .phase (acc_phase),
    .index (acc_index)
  );

  // Stage 1: table read registered alongside the sample (R3 pre-add phase)
  cmix_sincos #(.DW(DW), .QB(QB)) u_osc (
    .clk   (clk),
    .rst_n (rst_n),
    .idx   (acc_index),
    .sin_o (osc_s),
    .cos_o (osc_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_i   <= '0;
      s1_q   <= '0;
      s1_v   <= 1'b0;
      s1_dir <= 1'b0;
    end else begin
      s1_i   <= $signed(in_i);
      s1_q   <= $signed(in_q);
      s1_v   <= in_valid;
      s1_dir <= shift_down;   // R9: direction travels with its sample
    end
  end

  // Stages 2 and 3: multiply, then round/saturate
  cmix_cmul #(.DW(DW)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .vin   (s1_v),
    .swap  (s1_dir),
    .a_i   (s1_i),
    .a_q   (s1_q),
    .osc_s (osc_s),
    .osc_c (osc_c),
    .vout  (out_valid),
    .y_i   (r_i),
    .y_q   (r_q)
  );

  assign out_i = r_i;
  assign out_q = r_q;
endmodule

// File: rtl/cmix_checker.sv
module cmix_checker #(
  parameter int DW  = 12,
  parameter int PHW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [PHW-1:0] tune_word,
  input logic           out_valid,
  input logic [DW-1:0]  out_i,
  input logic [DW-1:0]  out_q,
  input logic [PHW-1:0] phase
);
  logic [1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seen <= 2'd0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_i == '0 && out_q == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(phase));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (phase == $past(phase) + $past(tune_word)));
endmodule

bind nco_cmix cmix_checker #(.DW(DW), .PHW(PHW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .tune_word (tune_word),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q),
  .phase     (acc_phase)
);

// File: tb/nco_cmix_test.sv
`timescale 1ns/1ps
module nco_cmix_test;
  localparam int  DW  = 12;
  localparam int  PHW = 32;
  localparam int  QB  = 4;
  localparam int  PB  = QB + 2;
  localparam int  NP  = 1 << PB;
  localparam int  AMP = 2047;
  localparam real TWO_PI = 6.283185307179586;
  localparam logic [31:0] ONE_STEP = 32'h1 << (32 - PB);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_i = '0, in_q = '0;
  logic [PHW-1:0] tune_word = '0;
  logic shift_down = 1'b0;
  logic out_valid;
  logic [DW-1:0] out_i, out_q;

  always #2 clk = ~clk;

  nco_cmix #(.DW(DW), .PHW(PHW), .QB(QB)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .tune_word(tune_word), .shift_down(shift_down),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] macc = '0;
  int exp_i[$], exp_q[$], exp_c[$];
  string exp_t[$];
  int seed = 32'h1d2c3b4a;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // R4 reference, written as a direct angle
  function automatic int wave(input int p);
    real x;
    x = real'(AMP) * $sin(TWO_PI * (real'(p % NP) + 0.5) / real'(NP));
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

  // R7 + R8 reference
  function automatic int scale(input longint y);
    real r;
    r = $floor((real'(y) + 1024.0) / 2048.0);
    if (r > 2047.0)  return 2047;
    if (r < -2048.0) return -2048;
    return int'(r);
  endfunction

  function automatic int rnd(input int lo, input int hi);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >>> 17);
    seed = seed ^ (seed << 5);
    return lo + int'((seed & 32'h7fffffff) % (hi - lo + 1));
  endfunction

  task automatic send(input int si, input int sq, input logic [31:0] ftw, input bit dir, input string tag);
    int p, s, c, ls, lc;
    longint yi, yq;
    @(negedge clk);
    in_valid = 1'b1; in_i = si[DW-1:0]; in_q = sq[DW-1:0];
    tune_word = ftw; shift_down = dir;
    p = int'(macc[31 -: PB]);
    s = wave(p);
    c = wave(p + NP / 4);
    ls = dir ? c : s;
    lc = dir ? s : c;
    yi = longint'(si) * lc - longint'(sq) * ls;
    yq = longint'(si) * ls + longint'(sq) * lc;
    exp_i.push_back(scale(yi));
    exp_q.push_back(scale(yq));
    exp_c.push_back(cyc);
    exp_t.push_back(tag);
    macc = macc + ftw;
  endtask

  // Gaps: tuning and direction wander but must be ignored (R3)
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
      tune_word = 32'(rnd(0, 32'h7fffffff));
      shift_down = ~shift_down;
      in_i = DW'(rnd(0, 4095)); in_q = DW'(rnd(0, 4095));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (out_valid) begin
        if (exp_i.size() == 0) begin
          check(1'b0, "R2", "unexpected out_valid", 1, 0);
        end else begin
          automatic int ei = exp_i.pop_front();
          automatic int eq = exp_q.pop_front();
          automatic int ec = exp_c.pop_front();
          automatic string et = exp_t.pop_front();
          check($signed(out_i) == ei, et, "out_i", int'($signed(out_i)), ei);
          check($signed(out_q) == eq, et, "out_q", int'($signed(out_q)), eq);
          check(cyc - ec == 3, "R2", "latency", cyc - ec, 3);
        end
      end else begin
        check(out_i == '0 && out_q == '0, "R1", "idle data", int'(out_i) | int'(out_q), 0);
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "reset valid", int'(out_valid), 0);
    check(out_i == '0 && out_q == '0, "R1", "reset data", int'(out_i), 0);
    rst_n = 1'b1;
    macc = '0;

    // R4: unit tone readout over every phase index
    for (int n = 0; n < NP; n++) send(2047, 0, ONE_STEP, 1'b0, "R4");
    for (int n = 0; n < NP; n++) send(0, 2047, ONE_STEP, 1'b0, "R4");
    // R6: reversed direction
    for (int n = 0; n < NP; n++) send(1500, -700, ONE_STEP, 1'b1, "R6");
    for (int n = 0; n < NP; n++) send(rnd(-2048, 2047), rnd(-2048, 2047), ONE_STEP, 1'b1, "R6");
    // R5: forward direction, mixed samples
    for (int n = 0; n < 2 * NP; n++) send(rnd(-2048, 2047), rnd(-2048, 2047), ONE_STEP, 1'b0, "R5");
    // R8: corner magnitudes drive the sums past full scale
    for (int n = 0; n < NP; n++) send(-2048, -2048, ONE_STEP, n[0], "R8");
    for (int n = 0; n < NP; n++) send(2047, 2047, ONE_STEP, n[1], "R8");
    for (int n = 0; n < NP; n++) send(-2048, 2047, ONE_STEP, n[0], "R8");
    // R7: tiny inputs, rounding decides everything
    for (int n = 0; n < 2 * NP; n++) send((n % 7) - 3, (n % 5) - 2, ONE_STEP, n[2], "R7");
    // R3: gaps between samples with noise on tuning and direction
    for (int n = 0; n < 80; n++) begin
      send(rnd(-2048, 2047), rnd(-2048, 2047), 32'h0123_4567, 1'b0, "R3");
      idle(rnd(1, 3));
    end
    // R9: tuning and direction change on every back-to-back sample
    for (int n = 0; n < 120; n++)
      send(rnd(-2048, 2047), rnd(-2048, 2047), 32'(rnd(0, 32'h7fffffff)) << 1, 1'(rnd(0, 1)), "R9");
    idle(8);
    check(exp_i.size() == 0, "R2", "pending results", exp_i.size(), 0);

    // R10: reset with samples in flight
    send(2047, 0, 32'h2000_0000, 1'b0, "R10");
    send(2047, 0, 32'h2000_0000, 1'b0, "R10");
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    exp_i.delete(); exp_q.delete(); exp_c.delete(); exp_t.delete();
    macc = '0;
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R10", "flushed sample", int'(out_valid), 0);
    end
    // First sample after reset must use phase 0 (R3, R10)
    send(2047, 0, 32'h4000_0000, 1'b0, "R10");
    send(2047, 0, 32'h4000_0000, 1'b0, "R10");
    idle(6);
    check(exp_i.size() == 0, "R2", "pending results", exp_i.size(), 0);
    finish_run();
  end
endmodule